// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of programmable breakpoint and watchpoint comparators for a 32-bit core. Once per cycle the core presents one access: what kind of operation it is (instruction fetch for execution, store, or load), the privilege level the hart is running at, the address involved and the data value involved. Every trigger looks at that access in parallel. The unit then reports whether a trigger fired and, if one did, which one. That result goes out one clock later, from a register.

Each trigger is built from two programmable words: a control word and a compare value. The control word enables the trigger per operation kind and per privilege level. It also chooses whether the address or the data is compared, chooses one of six comparison modes, and can link the trigger to the next one so that several conditions must all hold together. Software, or a debug module, loads these words through a narrow write port. On that port an index picks the trigger and a field bit picks the word. When the hart is halted, nothing is reported.

Top module: `brkpt_match_bank`

## Requirements
- R1: After reset, `hit` and `hit_idx` are 0, and every trigger has all of its operation and privilege enables cleared, so no access can produce a hit until a trigger has been written.
- R2: The result is registered. The access presented in one cycle shows up on `hit`/`hit_idx` after the next rising clock edge. Whenever `hit` is 0, `hit_idx` is 0.
- R3: Control bits 2, 1 and 0 enable execute (`acc_op`=0), store (`acc_op`=1) and load (`acc_op`=2) respectively. A trigger whose bit for the presented operation is clear does not match.
- R4: Control bits 3, 4, 5 and 6 enable privilege U (`acc_priv`=0), S (1), H (2) and M (3). A trigger whose bit for the current privilege is clear does not match.
- R5: Control bit 7 selects the compared value: 1 compares `acc_data`, 0 compares `acc_addr`.
- R6: Control bits 10:8 hold the mode. Mode 0 matches when the value equals the compare word. Mode 2 matches when the value is greater than or equal to the compare word, and mode 3 when it is less than the compare word. Both of these are unsigned comparisons.
- R7: Mode 1 (naturally aligned range) counts the unbroken run of 1 bits in the compare word starting at bit 0. That many low bits are ignored, and the remaining bits must be equal. A compare word of all ones matches every value.
- R8: Mode 4 uses the upper 16 bits of the compare word as a mask. It matches when the value and the compare word agree on every bit where the mask is 1.
- R9: Mode 5 uses the same mask. It matches when the upper 16 bits of the value agree with the lower 16 bits of the compare word on every bit where the mask is 1.
- R10: When several triggers qualify, the lowest-numbered trigger that is able to report is the one reported.
- R11: A trigger with control bit 11 (chain) set never reports itself. When it matches, the next trigger in index order is evaluated, and a hit is reported only by a following trigger whose chain bit is clear. A chained trigger at the last index can never cause a hit.
- R12: When a chained trigger fails to match, every following trigger up to and including the first one with its chain bit clear is suppressed. Evaluation resumes normally after that trigger.
- R13: While `hart_halted` is 1, the access in that cycle produces no hit.
- R14: A write with `cfg_we`=1 updates only the trigger chosen by `cfg_sel`. `cfg_field`=0 writes the control word and `cfg_field`=1 writes the compare word. Mode codes 6 and 7 never match, and `acc_op`=3 (no access) never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Trigger register write strobe |
| cfg_sel | input | 2 | Index of the trigger to write |
| cfg_field | input | 1 | 0 = control word, 1 = compare word |
| cfg_wdata | input | 32 | Write data (the control word uses bits 11:0) |
| hart_halted | input | 1 | Hart is halted in debug; suppresses hits |
| acc_op | input | 2 | 0 execute, 1 store, 2 load, 3 none |
| acc_priv | input | 2 | 0 U, 1 S, 2 H, 3 M |
| acc_addr | input | 32 | Access address |
| acc_data | input | 32 | Access data |
| hit | output | 1 | A trigger fired on the previous cycle's access |
| hit_idx | output | 2 | Index of the firing trigger, 0 when no hit |

## Verification
The bench probes each comparison mode exactly at its edges. For equal, greater-or-equal and less-than it uses values one below, at and one above the compare word, including values with the top bit set. A design that compared signed would report 0x7FFFFFFF as at or above 0x80000000 in the GE case. For the aligned range mode it uses a compare word with no trailing ones and one that is all ones. A design that counted the run wrongly would either match neighbouring addresses or miss the entire address space. The two mask modes are given values that agree only in the lower half or only in the upper half, so a design that swapped the halves or took the mask from the wrong bits reports the opposite result. For chaining, the bench checks three cases. A chain whose first link fails must also silence the partner, or the partner fires alone. Suppression must stop after the end of the chain, or a later independent trigger is lost. A chained trigger in the last slot must stay silent, or it fires without any partner.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

   localparam int CTL_W = 12;

   localparam logic [1:0] OP_EXEC  = 2'd0;
   localparam logic [1:0] OP_STORE = 2'd1;
   localparam logic [1:0] OP_LOAD  = 2'd2;
   localparam logic [1:0] OP_NONE  = 2'd3;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_H = 2'd2;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam logic [2:0] MODE_EQ     = 3'd0;
   localparam logic [2:0] MODE_RANGE2 = 3'd1;
   localparam logic [2:0] MODE_GE     = 3'd2;
   localparam logic [2:0] MODE_LT     = 3'd3;
   localparam logic [2:0] MODE_MSKLO  = 3'd4;
   localparam logic [2:0] MODE_MSKHI  = 3'd5;

   // control word, bit 11 down to bit 0
   typedef struct packed {
      logic       chain;
      logic [2:0] mode;
      logic       use_data;
      logic       en_m;
      logic       en_h;
      logic       en_s;
      logic       en_u;
      logic       en_exec;
      logic       en_store;
      logic       en_load;
   } ctl_t;

endpackage

// File: rtl/brkpt_cfg_regs.sv
module brkpt_cfg_regs
   import brkpt_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int XLEN     = 32,
   parameter int IDX_W    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [IDX_W-1:0]      cfg_sel,
   input  logic                  cfg_field,
   input  logic [XLEN-1:0]       cfg_wdata,
   output ctl_t                  ctl_o   [NUM_TRIG],
   output logic [XLEN-1:0]       tdata_o [NUM_TRIG]
);

   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
      logic sel_me;
      assign sel_me = cfg_we && (cfg_sel == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_o[g]   <= '0;
            tdata_o[g] <= '0;
         end else if (sel_me) begin
            if (cfg_field) begin
               tdata_o[g] <= cfg_wdata;
            end else begin
               ctl_o[g] <= ctl_t'(cfg_wdata[CTL_W-1:0]);
            end
         end
      end
   end

endmodule

// File: rtl/brkpt_compare.sv
module brkpt_compare
   import brkpt_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit MASK_MODES = 1'b1
) (
   input  ctl_t            ctl,
   input  logic [XLEN-1:0] tdata,
   input  logic [1:0]      op,
   input  logic [1:0]      priv,
   input  logic [XLEN-1:0] addr,
   input  logic [XLEN-1:0] data,
   output logic            cand
);

   localparam int HALF = XLEN / 2;

   logic            op_ok;
   logic            priv_ok;
   logic [XLEN-1:0] val;
   logic [XLEN-1:0] diff;
   logic [XLEN-1:0] range_keep;
   logic            m_eq, m_ge, m_lt, m_range, m_lo, m_hi;
   logic            mode_ok;

   always_comb begin
      unique case (op)
         OP_EXEC:  op_ok = ctl.en_exec;
         OP_STORE: op_ok = ctl.en_store;
         OP_LOAD:  op_ok = ctl.en_load;
         default:  op_ok = 1'b0;
      endcase
   end

   always_comb begin
      unique case (priv)
         PRIV_U:  priv_ok = ctl.en_u;
         PRIV_S:  priv_ok = ctl.en_s;
         PRIV_H:  priv_ok = ctl.en_h;
         default: priv_ok = ctl.en_m;
      endcase
   end

   assign val  = ctl.use_data ? data : addr;
   assign diff = val ^ tdata;

   // bit i is ignored when compare bits i..0 are all ones
   for (genvar i = 0; i < XLEN; i++) begin : g_keep
      assign range_keep[i] = ~(&tdata[i:0]);
   end

   assign m_eq    = (diff == '0);
   assign m_ge    = (val >= tdata);
   assign m_lt    = (val < tdata);
   assign m_range = ((diff & range_keep) == '0);

   if (MASK_MODES) begin : g_mask
      logic [HALF-1:0] hmask;
      logic [HALF-1:0] lo_diff;
      logic [HALF-1:0] hi_diff;
      assign hmask   = tdata[XLEN-1:HALF];
      assign lo_diff = val[HALF-1:0] ^ tdata[HALF-1:0];
      assign hi_diff = val[XLEN-1:HALF] ^ tdata[HALF-1:0];
      assign m_lo    = ((lo_diff & hmask) == '0);
      assign m_hi    = ((hi_diff & hmask) == '0);
   end else begin : g_nomask
      assign m_lo = 1'b0;
      assign m_hi = 1'b0;
   end

   always_comb begin
      case (ctl.mode)
         MODE_EQ:     mode_ok = m_eq;
         MODE_RANGE2: mode_ok = m_range;
         MODE_GE:     mode_ok = m_ge;
         MODE_LT:     mode_ok = m_lt;
         MODE_MSKLO:  mode_ok = m_lo;
         MODE_MSKHI:  mode_ok = m_hi;
         default:     mode_ok = 1'b0;
      endcase
   end

   assign cand = op_ok && priv_ok && mode_ok;

endmodule

// File: rtl/brkpt_chain_arb.sv
module brkpt_chain_arb #(
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = 2
) (
   input  logic [NUM_TRIG-1:0] cand_vec,
   input  logic [NUM_TRIG-1:0] chain_vec,
   output logic                found,
   output logic [IDX_W-1:0]    found_idx
);

   always_comb begin
      logic live;
      live      = 1'b1;
      found     = 1'b0;
      found_idx = '0;
      for (int i = 0; i < NUM_TRIG; i++) begin
         if (!live) begin
            // skip the rest of a broken chain, including its last link
            live = !chain_vec[i];
         end else if (!cand_vec[i]) begin
            if (chain_vec[i]) begin
               live = 1'b0;
            end
         end else if (!chain_vec[i] && !found) begin
            found     = 1'b1;
            found_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/brkpt_match_bank.sv
module brkpt_match_bank
   import brkpt_pkg::*;
#(
   parameter int NUM_TRIG   = 4,
   parameter int XLEN       = 32,
   parameter bit MASK_MODES = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [1:0]            cfg_sel,
   input  logic                  cfg_field,
   input  logic [XLEN-1:0]       cfg_wdata,
   input  logic                  hart_halted,
   input  logic [1:0]            acc_op,
   input  logic [1:0]            acc_priv,
   input  logic [XLEN-1:0]       acc_addr,
   input  logic [XLEN-1:0]       acc_data,
   output logic                  hit,
   output logic [1:0]            hit_idx
);

   localparam int IDX_W = 2;

   if (NUM_TRIG < 1 || NUM_TRIG > (1 << IDX_W)) begin : g_bad_count
      $error("brkpt_match_bank: NUM_TRIG must be between 1 and 4");
   end
   if (XLEN < 4 || (XLEN % 2) != 0 || XLEN < CTL_W) begin : g_bad_xlen
      $error("brkpt_match_bank: XLEN must be even and at least the control width");
   end

   ctl_t                ctl   [NUM_TRIG];
   logic [XLEN-1:0]     tdata [NUM_TRIG];
   logic [NUM_TRIG-1:0] cand_vec;
   logic [NUM_TRIG-1:0] chain_vec;
   logic                found;
   logic [IDX_W-1:0]    found_idx;

   brkpt_cfg_regs #(
      .NUM_TRIG (NUM_TRIG),
      .XLEN     (XLEN),
      .IDX_W    (IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_field (cfg_field),
      .cfg_wdata (cfg_wdata),
      .ctl_o     (ctl),
      .tdata_o   (tdata)
   );

   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_cmp
      brkpt_compare #(
         .XLEN       (XLEN),
         .MASK_MODES (MASK_MODES)
      ) u_cmp (
         .ctl   (ctl[g]),
         .tdata (tdata[g]),
         .op    (acc_op),
         .priv  (acc_priv),
         .addr  (acc_addr),
         .data  (acc_data),
         .cand  (cand_vec[g])
      );
      assign chain_vec[g] = ctl[g].chain;
   end

   brkpt_chain_arb #(
      .NUM_TRIG (NUM_TRIG),
      .IDX_W    (IDX_W)
   ) u_arb (
      .cand_vec  (cand_vec),
      .chain_vec (chain_vec),
      .found     (found),
      .found_idx (found_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit     <= 1'b0;
         hit_idx <= '0;
      end else begin
         hit     <= found && !hart_halted;
         hit_idx <= (found && !hart_halted) ? found_idx : '0;
      end
   end

endmodule

// File: rtl/brkpt_match_bank_chk.sv
module brkpt_match_bank_chk #(
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                hart_halted,
   input logic [1:0]          acc_op,
   input logic                hit,
   input logic [IDX_W-1:0]    hit_idx,
   input logic [NUM_TRIG-1:0] cand_vec,
   input logic [NUM_TRIG-1:0] chain_vec
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $past(!rst_n) |-> (!hit && hit_idx == '0));

   assert_idle_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> hit_idx == '0);

   assert_halt_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hart_halted) |-> !hit);

   assert_no_access_R14: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc_op) == 2'd3) |-> !hit);

   assert_from_candidate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((($past(cand_vec) >> hit_idx) & NUM_TRIG'(1)) != '0));

   assert_reporter_unchained_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((($past(chain_vec) >> hit_idx) & NUM_TRIG'(1)) == '0));

endmodule

bind brkpt_match_bank brkpt_match_bank_chk #(
   .NUM_TRIG (NUM_TRIG),
   .IDX_W    (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hart_halted (hart_halted),
   .acc_op      (acc_op),
   .hit         (hit),
   .hit_idx     (hit_idx),
   .cand_vec    (cand_vec),
   .chain_vec   (chain_vec)
);

// File: tb/test_brkpt_match_bank.sv
`timescale 1ns/1ps
module test_brkpt_match_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_field = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        hart_halted = 1'b0;
   logic [1:0]  acc_op = 2'd3;
   logic [1:0]  acc_priv = 2'd3;
   logic [31:0] acc_addr = '0;
   logic [31:0] acc_data = '0;
   logic        hit;
   logic [1:0]  hit_idx;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   brkpt_match_bank i_brkpt_match_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_field   (cfg_field),
      .cfg_wdata   (cfg_wdata),
      .hart_halted (hart_halted),
      .acc_op      (acc_op),
      .acc_priv    (acc_priv),
      .acc_addr    (acc_addr),
      .acc_data    (acc_data),
      .hit         (hit),
      .hit_idx     (hit_idx)
   );

   typedef struct packed {
      logic [11:0] ctl;
      logic [31:0] tdata;
      logic [1:0]  op;
      logic [1:0]  priv;
      logic [31:0] addr;
      logic [31:0] data;
      logic        exp;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VT [NV] = '{
      '{12'h07F, 32'h0000_1000, 2'd0, 2'd3, 32'h0000_1000, 32'h0, 1'b1},
      '{12'h07F, 32'h0000_1000, 2'd0, 2'd3, 32'h0000_1004, 32'h0, 1'b0},
      '{12'h07B, 32'h0000_1000, 2'd0, 2'd3, 32'h0000_1000, 32'h0, 1'b0},
      '{12'h07B, 32'h0000_1000, 2'd2, 2'd3, 32'h0000_1000, 32'h0, 1'b1},
      '{12'h07B, 32'h0000_1000, 2'd1, 2'd3, 32'h0000_1000, 32'h0, 1'b1},
      '{12'h07E, 32'h0000_1000, 2'd2, 2'd3, 32'h0000_1000, 32'h0, 1'b0},
      '{12'h077, 32'h0000_1000, 2'd1, 2'd0, 32'h0000_1000, 32'h0, 1'b0},
      '{12'h077, 32'h0000_1000, 2'd1, 2'd1, 32'h0000_1000, 32'h0, 1'b1},
      '{12'h05F, 32'h0000_1000, 2'd1, 2'd2, 32'h0000_1000, 32'h0, 1'b0},
      '{12'h03F, 32'h0000_1000, 2'd1, 2'd3, 32'h0000_1000, 32'h0, 1'b0},
      '{12'h0FF, 32'h0000_CAFE, 2'd2, 2'd3, 32'h0000_0001, 32'h0000_CAFE, 1'b1},
      '{12'h0FF, 32'h0000_CAFE, 2'd2, 2'd3, 32'h0000_CAFE, 32'h0000_0001, 1'b0},
      '{12'h27F, 32'h8000_0000, 2'd0, 2'd3, 32'h8000_0000, 32'h0, 1'b1},
      '{12'h27F, 32'h8000_0000, 2'd0, 2'd3, 32'h7FFF_FFFF, 32'h0, 1'b0},
      '{12'h27F, 32'h8000_0000, 2'd0, 2'd3, 32'hFFFF_FFFF, 32'h0, 1'b1},
      '{12'h37F, 32'h0000_0100, 2'd0, 2'd3, 32'h0000_00FF, 32'h0, 1'b1},
      '{12'h37F, 32'h0000_0100, 2'd0, 2'd3, 32'h0000_0100, 32'h0, 1'b0},
      '{12'h37F, 32'h0000_0100, 2'd0, 2'd3, 32'h8000_0000, 32'h0, 1'b0},
      '{12'h17F, 32'h2000_00FF, 2'd0, 2'd3, 32'h2000_0000, 32'h0, 1'b1},
      '{12'h17F, 32'h2000_00FF, 2'd0, 2'd3, 32'h2000_00AB, 32'h0, 1'b1},
      '{12'h17F, 32'h2000_00FF, 2'd0, 2'd3, 32'h2000_0100, 32'h0, 1'b0},
      '{12'h17F, 32'hFFFF_FFFF, 2'd0, 2'd3, 32'h1234_5678, 32'h0, 1'b1},
      '{12'h17F, 32'h0000_1000, 2'd0, 2'd3, 32'h0000_1000, 32'h0, 1'b1},
      '{12'h17F, 32'h0000_1000, 2'd0, 2'd3, 32'h0000_1001, 32'h0, 1'b0},
      '{12'h47F, 32'h00F0_0030, 2'd0, 2'd3, 32'hABCD_1234, 32'h0, 1'b1},
      '{12'h47F, 32'h00F0_0030, 2'd0, 2'd3, 32'h0000_0040, 32'h0, 1'b0},
      '{12'h57F, 32'hFF00_1200, 2'd0, 2'd3, 32'h12AB_0000, 32'h0, 1'b1},
      '{12'h57F, 32'hFF00_1200, 2'd0, 2'd3, 32'h0000_1200, 32'h0, 1'b0},
      '{12'h67F, 32'h0000_0000, 2'd0, 2'd3, 32'h0000_0000, 32'h0, 1'b0},
      '{12'h77F, 32'h0000_0000, 2'd0, 2'd3, 32'h0000_0000, 32'h0, 1'b0},
      '{12'h07F, 32'h0000_1000, 2'd3, 2'd3, 32'h0000_1000, 32'h0, 1'b0}
   };

   function automatic string vec_req(int i);
      if (i < 2)  return "R6";
      if (i < 6)  return "R3";
      if (i < 10) return "R4";
      if (i < 12) return "R5";
      if (i < 18) return "R6";
      if (i < 24) return "R7";
      if (i < 26) return "R8";
      if (i < 28) return "R9";
      return "R14";
   endfunction

   task automatic check(string req, logic exp_hit, logic [1:0] exp_idx);
      tests++;
      if (hit !== exp_hit || hit_idx !== exp_idx) begin
         fails++;
         $display("FAIL %s: hit=%0b idx=%0d, expected hit=%0b idx=%0d",
                  req, hit, hit_idx, exp_hit, exp_idx);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic field, logic [31:0] val);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_field = field;
      cfg_wdata = val;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic clear_all();
      for (int k = 0; k < 4; k++) begin
         wr(2'(k), 1'b0, 32'h0);
      end
   endtask

   task automatic probe(logic [1:0] op, logic [1:0] priv, logic [31:0] a, logic [31:0] d);
      acc_op   = op;
      acc_priv = priv;
      acc_addr = a;
      acc_data = d;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state and disabled triggers
      check("R1 reset outputs", 1'b0, 2'd0);
      probe(2'd0, 2'd3, 32'h0, 32'h0);
      check("R1 reset triggers disabled", 1'b0, 2'd0);
      probe(2'd2, 2'd0, 32'h0, 32'h0);
      check("R1 reset triggers disabled load/U", 1'b0, 2'd0);

      // table walk on trigger 0
      for (int i = 0; i < NV; i++) begin
         wr(2'd0, 1'b0, {20'h0, VT[i].ctl});
         wr(2'd0, 1'b1, VT[i].tdata);
         probe(VT[i].op, VT[i].priv, VT[i].addr, VT[i].data);
         check(vec_req(i), VT[i].exp, 2'd0);
      end

      // R2: one-cycle registered latency
      clear_all();
      probe(2'd3, 2'd3, 32'h0, 32'h0);
      wr(2'd0, 1'b0, 32'h07F);
      wr(2'd0, 1'b1, 32'h0000_1000);
      acc_op = 2'd0; acc_priv = 2'd3; acc_addr = 32'h0000_1000;
      #1;
      check("R2 no hit before edge", 1'b0, 2'd0);
      @(negedge clk);
      check("R2 hit after one edge", 1'b1, 2'd0);
      probe(2'd0, 2'd3, 32'h0000_2000, 32'h0);
      check("R2 hit drops next cycle", 1'b0, 2'd0);

      // R14: write routed by index only
      clear_all();
      wr(2'd2, 1'b0, 32'h07F);
      wr(2'd2, 1'b1, 32'h0000_0040);
      probe(2'd0, 2'd3, 32'h0000_0040, 32'h0);
      check("R14 write reaches selected trigger", 1'b1, 2'd2);

      // R10: priority
      clear_all();
      for (int k = 1; k < 4; k++) begin
         wr(2'(k), 1'b0, 32'h07F);
         wr(2'(k), 1'b1, 32'h0000_0040);
      end
      probe(2'd0, 2'd3, 32'h0000_0040, 32'h0);
      check("R10 lowest index wins", 1'b1, 2'd1);
      wr(2'd1, 1'b0, 32'h0);
      probe(2'd0, 2'd3, 32'h0000_0040, 32'h0);
      check("R10 next index after disable", 1'b1, 2'd2);

      // R13: halted
      hart_halted = 1'b1;
      probe(2'd0, 2'd3, 32'h0000_0040, 32'h0);
      check("R13 halted suppresses", 1'b0, 2'd0);
      hart_halted = 1'b0;
      probe(2'd0, 2'd3, 32'h0000_0040, 32'h0);
      check("R13 resumes after halt", 1'b1, 2'd2);

      // R11 / R12: chaining
      clear_all();
      wr(2'd0, 1'b0, 32'h87F);
      wr(2'd0, 1'b1, 32'h0000_0040);
      wr(2'd1, 1'b0, 32'h0FF);
      wr(2'd1, 1'b1, 32'h0000_0055);
      probe(2'd0, 2'd3, 32'h0000_0040, 32'h0000_0055);
      check("R11 chain pair reports at end", 1'b1, 2'd1);
      probe(2'd0, 2'd3, 32'h0000_0040, 32'h0000_0056);
      check("R11 chained match alone silent", 1'b0, 2'd0);
      probe(2'd0, 2'd3, 32'h0000_0044, 32'h0000_0055);
      check("R12 broken chain suppresses partner", 1'b0, 2'd0);
      wr(2'd2, 1'b0, 32'h07F);
      wr(2'd2, 1'b1, 32'h0000_0044);
      probe(2'd0, 2'd3, 32'h0000_0044, 32'h0000_0055);
      check("R12 suppression ends after chain", 1'b1, 2'd2);
      probe(2'd0, 2'd3, 32'h0000_0040, 32'h0000_0055);
      check("R10 chain end outranks later trigger", 1'b1, 2'd1);
      clear_all();
      wr(2'd3, 1'b0, 32'h87F);
      wr(2'd3, 1'b1, 32'h0000_0080);
      probe(2'd0, 2'd3, 32'h0000_0080, 32'h0);
      check("R11 chained last trigger silent", 1'b0, 2'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule